// File: doc/BRIEF.md
# CAN Receive Acceptance Filter Bank

This block decides whether a CAN frame that the receiver has just finished should be written into the receive FIFO. Each valid frame arrives as a one-cycle strobe together with its identifier, its IDE bit and its RTR bit. When filtering is switched off, every frame is kept. When it is switched on, the frame is compared against a bank of filter/mask pairs, and it is kept only if at least one pair accepts it.

The frame is first turned into a comparison key holding the 29-bit identifier, the IDE bit and the RTR bit. A standard frame's 11-bit identifier fills the top identifier bits, and the bits that only extended frames carry are forced to zero. Each filter compares the key under its own mask. The lowest-numbered filter that accepts the frame is the one reported. One cycle after the strobe, the block gives a store pulse and a hit code. The hit code holds its value until the next frame.

Top module: `can_accept_filter`

## Requirements
- R1: While reset is asserted and after it is released, `store_o` is 0 and `hit_o` is 4'b0000 until the first valid frame.
- R2: With `filt_en_i` low, every frame strobed by `frm_vld_i` gives `store_o`=1 and `hit_o`=4'b0000, whatever the filter and mask contents are.
- R3: The comparison key is 31 bits: bits [30:2] hold the identifier, bit 1 holds IDE and bit 0 holds RTR. Filter n and mask n take bits [n*31 +: 31] of `flt_key_i` and `msk_key_i`. A key bit counts toward a match only where the mask bit is 1. A mask bit of 0 makes that key bit don't-care.
- R4: When several filters accept a frame, the lowest-numbered one is reported.
- R5: A match on filter n (0 to 7) is reported as `hit_o` = {1'b1, n[2:0]}, so filter 0 gives 4'b1000 and filter 7 gives 4'b1111. `store_o` is 1.
- R6: With filtering on, a frame that no filter accepts gives `store_o`=0 and `hit_o`=4'b0000.
- R7: When IDE is 0, the standard identifier is taken from `frm_id_i[10:0]` and placed in key bits [30:20]. Key bits [19:2] are zero, and `frm_id_i[28:11]` has no effect on the result.
- R8: When IDE is 1, all 29 bits of `frm_id_i` enter the key, with `frm_id_i[28]` in key bit 30.
- R9: The decision appears in the cycle after the `frm_vld_i` edge. `store_o` is a single-cycle pulse that occurs only after a strobe, and `hit_o` holds its value in cycles without a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frm_vld_i | input | 1 | One-cycle strobe marking a valid received frame |
| frm_ide_i | input | 1 | Frame format bit (1 = extended) |
| frm_rtr_i | input | 1 | Remote request bit of the frame |
| frm_id_i | input | 29 | Received identifier; standard frames use bits [10:0] |
| filt_en_i | input | 1 | Global filtering enable |
| flt_key_i | input | 248 | Eight packed 31-bit filter keys |
| msk_key_i | input | 248 | Eight packed 31-bit masks |
| store_o | output | 1 | Pulse: write the frame into the receive FIFO |
| hit_o | output | 4 | Code of the accepting filter, 0000 for none or filtering off |

## Verification
The case that is hardest to reach is a frame that several filters accept at once, where only the lowest index may be reported. Random filter and mask values almost never produce such overlaps. The stimulus therefore builds frames from a chosen filter's key, with random values only in that filter's don't-care bits, and uses sparse masks so that other filters often accept the same frame. Directed cases put identical keys in two filters and send standard frames with random upper identifier bits.

// File: rtl/can_afilt_pkg.sv
`timescale 1ns/1ps
package can_afilt_pkg;
   localparam int unsigned EXT_ID_W_DEF = 29;
   localparam int unsigned STD_ID_W_DEF = 11;
   localparam int unsigned NUM_FLT_DEF  = 8;
   // key layout: {identifier, ide, rtr}
   localparam int unsigned KEY_IDE_BIT  = 1;
   localparam int unsigned KEY_RTR_BIT  = 0;
endpackage

// File: rtl/can_afilt_keygen.sv
`timescale 1ns/1ps
module can_afilt_keygen #(
   parameter int unsigned EXT_ID_W = 29,
   parameter int unsigned STD_ID_W = 11,
   localparam int unsigned KEY_W   = EXT_ID_W + 2,
   localparam int unsigned PAD_W   = EXT_ID_W - STD_ID_W
) (
   input  logic                ide_i,
   input  logic                rtr_i,
   input  logic [EXT_ID_W-1:0] id_i,
   output logic [KEY_W-1:0]    key_o
);
   logic [EXT_ID_W-1:0] id_norm;

   always_comb begin
      if (ide_i) id_norm = id_i;
      else       id_norm = {id_i[STD_ID_W-1:0], {PAD_W{1'b0}}};
      key_o = {id_norm, ide_i, rtr_i};
   end
endmodule

// File: rtl/can_afilt_cmp.sv
`timescale 1ns/1ps
module can_afilt_cmp #(
   parameter int unsigned KEY_W = 31
) (
   input  logic [KEY_W-1:0] key_i,
   input  logic [KEY_W-1:0] flt_i,
   input  logic [KEY_W-1:0] msk_i,
   output logic             match_o
);
   logic [KEY_W-1:0] diff;

   always_comb begin
      diff    = (key_i ^ flt_i) & msk_i;
      match_o = ~|diff;
   end
endmodule

// File: rtl/can_afilt_prio.sv
`timescale 1ns/1ps
module can_afilt_prio #(
   parameter int unsigned N     = 8,
   localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);
   always_comb begin
      any_o = |req_i;
      idx_o = '0;
      // walk from the top so the lowest requester is written last and wins
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = IDX_W'(i);
      end
   end
endmodule

// File: rtl/can_accept_filter.sv
`timescale 1ns/1ps
module can_accept_filter #(
   parameter int unsigned NUM_FLT  = can_afilt_pkg::NUM_FLT_DEF,
   parameter int unsigned EXT_ID_W = can_afilt_pkg::EXT_ID_W_DEF,
   parameter int unsigned STD_ID_W = can_afilt_pkg::STD_ID_W_DEF,
   localparam int unsigned KEY_W   = EXT_ID_W + 2,
   localparam int unsigned IDX_W   = $clog2(NUM_FLT),
   localparam int unsigned HIT_W   = IDX_W + 1
) (
   input  logic                     clk_i,
   input  logic                     rst_ni,
   input  logic                     frm_vld_i,
   input  logic                     frm_ide_i,
   input  logic                     frm_rtr_i,
   input  logic [EXT_ID_W-1:0]      frm_id_i,
   input  logic                     filt_en_i,
   input  logic [NUM_FLT*KEY_W-1:0] flt_key_i,
   input  logic [NUM_FLT*KEY_W-1:0] msk_key_i,
   output logic                     store_o,
   output logic [HIT_W-1:0]         hit_o
);
   if (NUM_FLT < 2 || NUM_FLT != (1 << IDX_W)) begin : g_bad_num
      $error("NUM_FLT must be a power of two of at least 2");
   end
   if (STD_ID_W >= EXT_ID_W) begin : g_bad_id
      $error("STD_ID_W must be narrower than EXT_ID_W");
   end

   logic [KEY_W-1:0]   key;
   logic [NUM_FLT-1:0] match;
   logic               any_match;
   logic [IDX_W-1:0]   win_idx;
   logic               store_d;
   logic [HIT_W-1:0]   hit_d;

   can_afilt_keygen #(.EXT_ID_W(EXT_ID_W), .STD_ID_W(STD_ID_W)) u_keygen (
      .ide_i (frm_ide_i),
      .rtr_i (frm_rtr_i),
      .id_i  (frm_id_i),
      .key_o (key)
   );

   for (genvar n = 0; n < NUM_FLT; n++) begin : g_flt
      can_afilt_cmp #(.KEY_W(KEY_W)) u_cmp (
         .key_i   (key),
         .flt_i   (flt_key_i[n*KEY_W +: KEY_W]),
         .msk_i   (msk_key_i[n*KEY_W +: KEY_W]),
         .match_o (match[n])
      );
   end

   can_afilt_prio #(.N(NUM_FLT)) u_prio (
      .req_i (match),
      .any_o (any_match),
      .idx_o (win_idx)
   );

   always_comb begin
      if (!filt_en_i) begin
         store_d = 1'b1;
         hit_d   = '0;
      end else if (any_match) begin
         store_d = 1'b1;
         hit_d   = {1'b1, win_idx};
      end else begin
         store_d = 1'b0;
         hit_d   = '0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         store_o <= 1'b0;
         hit_o   <= '0;
      end else if (frm_vld_i) begin
         store_o <= store_d;
         hit_o   <= hit_d;
      end else begin
         store_o <= 1'b0;
      end
   end
endmodule

// File: rtl/can_afilt_chk.sv
`timescale 1ns/1ps
module can_afilt_chk #(
   parameter int unsigned NUM_FLT  = 8,
   parameter int unsigned EXT_ID_W = 29,
   parameter int unsigned STD_ID_W = 11,
   localparam int unsigned KEY_W   = EXT_ID_W + 2,
   localparam int unsigned HIT_W   = $clog2(NUM_FLT) + 1
) (
   input logic                     clk_i,
   input logic                     rst_ni,
   input logic                     frm_vld_i,
   input logic                     frm_ide_i,
   input logic                     frm_rtr_i,
   input logic [EXT_ID_W-1:0]      frm_id_i,
   input logic                     filt_en_i,
   input logic [NUM_FLT*KEY_W-1:0] flt_key_i,
   input logic [NUM_FLT*KEY_W-1:0] msk_key_i,
   input logic                     store_o,
   input logic [HIT_W-1:0]         hit_o
);
   logic [KEY_W-1:0] chk_key;
   logic             f0_ok;
   logic             flast_only;

   always_comb begin
      chk_key = frm_ide_i ? {frm_id_i, 2'b10 | {1'b0, frm_rtr_i}}
                          : {frm_id_i[STD_ID_W-1:0], {(EXT_ID_W-STD_ID_W){1'b0}}, 1'b0, frm_rtr_i};
      f0_ok = ((chk_key ^ flt_key_i[KEY_W-1:0]) & msk_key_i[KEY_W-1:0]) == '0;
      flast_only = 1'b1;
      for (int n = 0; n < NUM_FLT; n++) begin
         if ((((chk_key ^ flt_key_i[n*KEY_W +: KEY_W]) & msk_key_i[n*KEY_W +: KEY_W]) == '0)
             != (n == NUM_FLT - 1))
            flast_only = 1'b0;
      end
   end

   p_reset_quiet_r1: assert property (@(posedge clk_i) !rst_ni |=> (!store_o && hit_o == '0));
   p_off_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frm_vld_i && !filt_en_i) |=> (store_o && hit_o == '0));
   p_first_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frm_vld_i && filt_en_i && f0_ok) |=> (store_o && hit_o == {1'b1, {(HIT_W-1){1'b0}}}));
   p_last_code_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frm_vld_i && filt_en_i && flast_only) |=> (store_o && hit_o == '1));
   p_code_store_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frm_vld_i && filt_en_i) |=> (store_o == hit_o[HIT_W-1]));
   p_no_stray_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !frm_vld_i |=> !store_o);
   p_hit_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!frm_vld_i && $past(rst_ni)) |=> $stable(hit_o));
endmodule

bind can_accept_filter can_afilt_chk #(
   .NUM_FLT(NUM_FLT), .EXT_ID_W(EXT_ID_W), .STD_ID_W(STD_ID_W)
) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .frm_vld_i(frm_vld_i), .frm_ide_i(frm_ide_i),
   .frm_rtr_i(frm_rtr_i), .frm_id_i(frm_id_i), .filt_en_i(filt_en_i),
   .flt_key_i(flt_key_i), .msk_key_i(msk_key_i), .store_o(store_o), .hit_o(hit_o)
);

// File: tb/test_can_accept_filter.sv
`timescale 1ns/1ps
module test_can_accept_filter;
   localparam int NF = 8, EW = 29, SW = 11, KW = 31, HW = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic           vld = 0, ide = 0, rtr = 0, en = 0;
   logic [EW-1:0]  id = '0;
   logic [NF*KW-1:0] flt = '0, msk = '0;
   logic           store;
   logic [HW-1:0]  hit;
   int errs = 0, checks = 0;
   bit done = 0;

   can_accept_filter i_can_accept_filter (
      .clk_i(clk), .rst_ni(rst_n), .frm_vld_i(vld), .frm_ide_i(ide), .frm_rtr_i(rtr),
      .frm_id_i(id), .filt_en_i(en), .flt_key_i(flt), .msk_key_i(msk),
      .store_o(store), .hit_o(hit)
   );

   function automatic logic [KW-1:0] key_of(logic f_ide, logic f_rtr, logic [EW-1:0] f_id);
      if (f_ide) return {f_id, 1'b1, f_rtr};
      return {f_id[SW-1:0], {(EW-SW){1'b0}}, 1'b0, f_rtr};
   endfunction

   function automatic logic [HW:0] expect_of(logic f_ide, logic f_rtr, logic [EW-1:0] f_id);
      logic [KW-1:0] k = key_of(f_ide, f_rtr, f_id);
      if (!en) return {1'b1, 4'b0000};
      for (int n = 0; n < NF; n++)
         if (((k ^ flt[n*KW +: KW]) & msk[n*KW +: KW]) == '0) return {1'b1, 1'b1, 3'(n)};
      return '0;
   endfunction

   task automatic check(string req, logic [HW:0] act, logic [HW:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: {store,hit} actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic send(logic f_ide, logic f_rtr, logic [EW-1:0] f_id, string req);
      logic [HW:0] exp;
      @(negedge clk);
      ide = f_ide; rtr = f_rtr; id = f_id; vld = 1'b1;
      exp = expect_of(f_ide, f_rtr, f_id);
      @(negedge clk);
      vld = 1'b0;
      check(req, {store, hit}, exp);
   endtask

   task automatic idle(string req);
      logic [HW-1:0] held = hit;
      @(negedge clk);
      check(req, {store, hit}, {1'b0, held});
   endtask

   task automatic set_f(int n, logic [KW-1:0] f, logic [KW-1:0] m);
      flt[n*KW +: KW] = f;
      msk[n*KW +: KW] = m;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         errs++;
         $display("FAIL watchdog: run did not complete");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      logic [KW-1:0] k;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check("R1 in reset", {store, hit}, 5'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", {store, hit}, 5'b0);

      // R2: filtering disabled, no filter would accept
      for (int n = 0; n < NF; n++) set_f(n, '1, '1);
      en = 0;
      send(1'b1, 1'b0, 29'h0ABCDEF, "R2 disabled accepts");
      idle("R9 no pulse when idle");

      // R6: enabled, nothing matches
      en = 1;
      send(1'b1, 1'b0, 29'h0ABCDEF, "R6 no match not stored");

      // R3/R5: zero mask on filter 0 accepts anything
      set_f(0, '1, '0);
      send(1'b0, 1'b1, 29'h123, "R3 zero mask don't-care");
      check("R5 filter0 code", {store, hit}, 5'b11000);
      idle("R9 hit holds");

      // R5: only filter 7 accepts
      set_f(0, '1, '1);
      k = key_of(1'b1, 1'b1, 29'h15555555);
      set_f(7, k, '1);
      send(1'b1, 1'b1, 29'h15555555, "R5 filter7 code 1111");
      // R8: one identifier bit different under a set mask bit
      send(1'b1, 1'b1, 29'h15555554, "R8 ext lsb compared");

      // R4: filters 2 and 5 both accept
      k = key_of(1'b1, 1'b0, 29'h0000777);
      set_f(2, k, '1);
      set_f(5, k, '1);
      send(1'b1, 1'b0, 29'h0000777, "R4 lowest of 2 and 5");
      check("R4 code 1010", {store, hit}, 5'b11010);

      // R7: standard frame with junk upper bits
      k = key_of(1'b0, 1'b0, 29'h5A5);
      set_f(3, k, '1);
      send(1'b0, 1'b0, {18'h3FFFF, 11'h5A5}, "R7 upper bits ignored");
      check("R7 code 1011", {store, hit}, 5'b11011);
      send(1'b1, 1'b0, 29'h5A5, "R8 ide distinguishes");

      // random mix
      for (int it = 0; it < 3000; it++) begin
         logic [KW-1:0] fk, mk;
         int t;
         if (it % 150 == 0) begin
            for (int n = 0; n < NF; n++)
               set_f(n, KW'($urandom), KW'($urandom & $urandom & $urandom));
         end
         en = ($urandom % 8) != 0;
         t  = $urandom % NF;
         fk = flt[t*KW +: KW];
         mk = msk[t*KW +: KW];
         k  = ($urandom % 2) ? ((fk & mk) | (KW'($urandom) & ~mk)) : KW'($urandom);
         if (k[1])
            send(1'b1, k[0], k[KW-1:2], "R3 random ext");
         else
            send(1'b0, k[0], {18'($urandom), k[KW-1:KW-SW]}, "R7 random std");
         if ($urandom % 4 == 0) idle("R9 random idle");
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule